// File: doc/BRIEF.md
# Region Protection Address Translator

This block translates and guards addresses for a processor core that has no paged memory management. The 32-bit address space is cut into eight fixed regions of 512 MB each, and the top three address bits pick the region directly, with no tag compare. Each region holds a writable entry with a 3-bit physical region number and a 4-bit attribute code. The attribute code selects the access rights (read, write, execute) and the cache mode from one fixed decode table.

Two independent entry banks exist. Instruction fetches use the instruction bank, and loads and stores use the data bank. A lookup gives the physical address, the cache mode and a fault cause. The fault cause depends on whether the access kind is allowed by the region's attribute. The result appears on registered outputs one cycle after the request. A write port updates one entry of one bank per cycle.

Top module: `rgn_xlat`

## Requirements
- R1: The region index is address bits 31:29. The physical address is the selected entry's 3-bit region number placed in bits 31:29, with the request's bits 28:0 passed through unchanged. The physical address is reported even when the access faults.
- R2: The rights given by each attribute code are:
  - 0: read and write.
  - 1, 2, 4 and 5: read, write and execute.
  - 3: execute only.
  - 14: read and write.
  - Every other code: no rights.
- R3: The cache mode is encoded on `rs_cache` as 0 = bypass, 1 = write-through, 2 = write-back, 3 = isolate. The mode for each attribute code is:
  - Codes 0 and 1: write-through.
  - Code 2: bypass.
  - Codes 3, 4 and 5: write-back.
  - Code 14: isolate.
  - Every code without rights: bypass.
- R4: The access kind is encoded on `lk_kind` as 0 = load, 1 = store, 2 = fetch, 3 = load. A load needs read, a store needs write and a fetch needs execute. `rs_cause` is 0 when the access is allowed. On a fault it is 1 for a load, 2 for a store and 3 for a fetch.
- R5: Fetches read the instruction bank, and loads and stores read the data bank. `wr_side` = 0 writes the instruction bank and `wr_side` = 1 writes the data bank. A write to one bank never changes lookups in the other bank.
- R6: After reset, `rs_valid` is 0. Every entry i of both banks holds region number i and attribute 2, so every address maps to itself with full rights and bypass.
- R7: A write is seen by lookups issued in the cycle after the write strobe. A lookup issued in the same cycle as a write to its entry still sees the old contents.
- R8: `rs_valid` is high in the cycle after each cycle that `lk_valid` was high, and low otherwise. Back-to-back lookups give back-to-back results. When `rs_valid` is low, `rs_paddr` and `rs_cause` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| lk_addr | input | 32 | Virtual address to translate |
| wr_en | input | 1 | Entry write strobe |
| wr_side | input | 1 | Bank to write: 0 instruction, 1 data |
| wr_idx | input | 3 | Region index to write |
| wr_base | input | 3 | New physical region number |
| wr_attr | input | 4 | New attribute code |
| rs_valid | output | 1 | Result valid, one cycle after the request |
| rs_paddr | output | 32 | Translated physical address |
| rs_cache | output | 2 | Cache mode: 0 bypass, 1 write-through, 2 write-back, 3 isolate |
| rs_cause | output | 2 | Fault cause: 0 none, 1 load, 2 store, 3 fetch |

## Verification
The hardest case to reach is a write and a lookup to the same entry at the same clock edge. In that cycle the lookup must still return the old contents, and the next lookup must return the new ones. The stimulus issues both strobes together and follows at once with a second lookup to that entry. The second hard case is proving that the two banks stay apart. The bench writes a faulting attribute into one bank and then reads the same region index through the other bank's access kind. The bench also sweeps all sixteen attribute codes with all three access kinds.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

  localparam int ATTR_BITS = 4;

  typedef enum logic [1:0] {
    K_LOAD  = 2'd0,
    K_STORE = 2'd1,
    K_FETCH = 2'd2,
    K_LOAD2 = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    CM_BYPASS = 2'd0,
    CM_WTHRU  = 2'd1,
    CM_WBACK  = 2'd2,
    CM_ISOL   = 2'd3
  } cmode_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LOAD  = 2'd1,
    FLT_STORE = 2'd2,
    FLT_FETCH = 2'd3
  } fault_e;

  typedef struct packed {
    logic   rd;
    logic   wr;
    logic   ex;
    cmode_e cm;
  } perm_t;

  // Fixed attribute decode: rights and cache mode per code
  function automatic perm_t attr_decode(input logic [ATTR_BITS-1:0] code);
    perm_t p;
    p = '{rd: 1'b0, wr: 1'b0, ex: 1'b0, cm: CM_BYPASS};
    case (code)
      4'd0:  p = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, cm: CM_WTHRU};
      4'd1:  p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cm: CM_WTHRU};
      4'd2:  p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cm: CM_BYPASS};
      4'd3:  p = '{rd: 1'b0, wr: 1'b0, ex: 1'b1, cm: CM_WBACK};
      4'd4,
      4'd5:  p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cm: CM_WBACK};
      4'd14: p = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, cm: CM_ISOL};
      default: p = '{rd: 1'b0, wr: 1'b0, ex: 1'b0, cm: CM_BYPASS};
    endcase
    return p;
  endfunction

  // Right needed by an access kind
  function automatic logic kind_allowed(input kind_e k, input perm_t p);
    case (k)
      K_STORE: return p.wr;
      K_FETCH: return p.ex;
      default: return p.rd;
    endcase
  endfunction

  function automatic fault_e kind_fault(input kind_e k);
    case (k)
      K_STORE: return FLT_STORE;
      K_FETCH: return FLT_FETCH;
      default: return FLT_LOAD;
    endcase
  endfunction

endpackage

// File: rtl/rgn_table.sv
module rgn_table #(
  parameter int IDX_W      = 3,
  parameter int ATTR_W     = 4,
  parameter int RESET_ATTR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [IDX_W-1:0]  wbase_i,
  input  logic [ATTR_W-1:0] wattr_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [IDX_W-1:0]  rbase_o,
  output logic [ATTR_W-1:0] rattr_o
);
  localparam int N_ENT = 1 << IDX_W;

  logic [IDX_W-1:0]  base_q [N_ENT];
  logic [ATTR_W-1:0] attr_q [N_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) begin
        base_q[i] <= IDX_W'(i);
        attr_q[i] <= ATTR_W'(RESET_ATTR);
      end
    end else if (we_i) begin
      base_q[widx_i] <= wbase_i;
      attr_q[widx_i] <= wattr_i;
    end
  end

  assign rbase_o = base_q[ridx_i];
  assign rattr_o = attr_q[ridx_i];

  // R7
  wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (base_q[$past(widx_i)] == $past(wbase_i)) &&
             (attr_q[$past(widx_i)] == $past(wattr_i)));

endmodule

// File: rtl/rgn_check.sv
module rgn_check
  import rgn_pkg::*;
(
  input  kind_e                kind_i,
  input  logic [ATTR_BITS-1:0] attr_i,
  output cmode_e               cmode_o,
  output fault_e               fault_o,
  output logic                 granted_o
);
  perm_t perm;

  always_comb begin
    perm      = attr_decode(attr_i);
    granted_o = kind_allowed(kind_i, perm);
    cmode_o   = perm.cm;
    fault_o   = granted_o ? FLT_NONE : kind_fault(kind_i);
  end

  always_comb begin
    // R4
    if (fault_o == FLT_STORE) begin
      store_cause_chk: assert (kind_i == K_STORE);
    end
    // R2
    if (cmode_o == CM_ISOL) begin
      isol_rights_chk: assert (attr_i == 4'd14);
    end
  end

endmodule

// File: rtl/rgn_xlat.sv
module rgn_xlat
  import rgn_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int ATTR_W = ATTR_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [1:0]        lk_kind,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              wr_en,
  input  logic              wr_side,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  wr_base,
  input  logic [ATTR_W-1:0] wr_attr,
  output logic              rs_valid,
  output logic [ADDR_W-1:0] rs_paddr,
  output logic [1:0]        rs_cache,
  output logic [1:0]        rs_cause
);
  localparam int OFF_W   = ADDR_W - IDX_W;
  localparam int N_SIDES = 2;

  function automatic logic [ADDR_W-1:0] form_paddr(input logic [IDX_W-1:0] base,
                                                   input logic [ADDR_W-1:0] va);
    return {base, va[OFF_W-1:0]};
  endfunction

  kind_e             lk_k;
  logic              look_side;
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  side_base [N_SIDES];
  logic [ATTR_W-1:0] side_attr [N_SIDES];
  logic [IDX_W-1:0]  sel_base;
  logic [ATTR_W-1:0] sel_attr;
  cmode_e            look_cmode;
  fault_e            look_fault;
  logic              look_granted;

  assign lk_k      = kind_e'(lk_kind);
  assign look_side = (lk_k != K_FETCH);
  assign lk_idx    = lk_addr[ADDR_W-1 -: IDX_W];

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    rgn_table #(.IDX_W(IDX_W), .ATTR_W(ATTR_W), .RESET_ATTR(2)) u_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (wr_en && (wr_side == 1'(s))),
      .widx_i  (wr_idx),
      .wbase_i (wr_base),
      .wattr_i (wr_attr),
      .ridx_i  (lk_idx),
      .rbase_o (side_base[s]),
      .rattr_o (side_attr[s])
    );
  end

  assign sel_base = side_base[look_side];
  assign sel_attr = side_attr[look_side];

  rgn_check u_chk (
    .kind_i    (lk_k),
    .attr_i    (sel_attr),
    .cmode_o   (look_cmode),
    .fault_o   (look_fault),
    .granted_o (look_granted)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_paddr <= '0;
      rs_cache <= '0;
      rs_cause <= '0;
    end else begin
      rs_valid <= lk_valid;
      if (lk_valid) begin
        rs_paddr <= form_paddr(sel_base, lk_addr);
        rs_cache <= look_cmode;
        rs_cause <= look_fault;
      end else begin
        rs_paddr <= '0;
        rs_cache <= '0;
        rs_cause <= '0;
      end
    end
  end

  // R8
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);

  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid && (rs_cause == 2'd0) && (rs_paddr == '0));

  // R1
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_paddr[OFF_W-1:0] == $past(lk_addr[OFF_W-1:0]));

  // R4
  grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> ((rs_cause == 2'd0) == $past(look_granted)));

endmodule

// File: tb/test_rgn_xlat.sv
module test_rgn_xlat;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [1:0]  lk_kind = 2'd0;
  logic [31:0] lk_addr = 32'd0;
  logic        wr_en = 1'b0;
  logic        wr_side = 1'b0;
  logic [2:0]  wr_idx = 3'd0;
  logic [2:0]  wr_base = 3'd0;
  logic [3:0]  wr_attr = 4'd0;
  logic        rs_valid;
  logic [31:0] rs_paddr;
  logic [1:0]  rs_cache;
  logic [1:0]  rs_cause;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] pa;
    logic [1:0]  cm;
    logic [1:0]  cz;
    string       rq;
  } exp_t;

  exp_t        sb[$];
  logic [2:0]  m_base [2][8];
  logic [3:0]  m_attr [2][8];

  always #10 clk = ~clk;

  rgn_xlat i_rgn_xlat (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_kind(lk_kind), .lk_addr(lk_addr),
    .wr_en(wr_en), .wr_side(wr_side), .wr_idx(wr_idx),
    .wr_base(wr_base), .wr_attr(wr_attr),
    .rs_valid(rs_valid), .rs_paddr(rs_paddr),
    .rs_cache(rs_cache), .rs_cause(rs_cause)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Own model of the rights and cache table
  function automatic exp_t predict(input logic [1:0] k, input logic [31:0] a,
                                   input string rq);
    exp_t e;
    int   sd;
    logic [3:0] at;
    logic r, w, x, need;
    sd = (k == 2'd2) ? 0 : 1;
    at = m_attr[sd][a[31:29]];
    r  = (at <= 4'd2) || (at == 4'd4) || (at == 4'd5) || (at == 4'd14);
    w  = r;
    x  = (at >= 4'd1) && (at <= 4'd5);
    e.cm = (at == 4'd14) ? 2'd3 :
           (at <= 4'd1) ? 2'd1 :
           (at >= 4'd3 && at <= 4'd5) ? 2'd2 : 2'd0;
    need = (k == 2'd1) ? w : (k == 2'd2) ? x : r;
    e.cz = need ? 2'd0 : (k == 2'd1) ? 2'd2 : (k == 2'd2) ? 2'd3 : 2'd1;
    e.pa = {m_base[sd][a[31:29]], a[28:0]};
    e.rq = rq;
    return e;
  endfunction

  task automatic look(input logic [1:0] k, input logic [31:0] a, input string rq);
    sb.push_back(predict(k, a, rq));
    lk_valid = 1'b1; lk_kind = k; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic wr(input logic s, input logic [2:0] ix, input logic [2:0] b,
                    input logic [3:0] at);
    wr_en = 1'b1; wr_side = s; wr_idx = ix; wr_base = b; wr_attr = at;
    @(negedge clk);
    wr_en = 1'b0;
    m_base[s][ix] = b;
    m_attr[s][ix] = at;
  endtask

  // Write and lookup in the same cycle: lookup sees old contents (R7)
  task automatic both(input logic s, input logic [2:0] ix, input logic [2:0] b,
                      input logic [3:0] at, input logic [1:0] k,
                      input logic [31:0] a);
    sb.push_back(predict(k, a, "R7"));
    wr_en = 1'b1; wr_side = s; wr_idx = ix; wr_base = b; wr_attr = at;
    lk_valid = 1'b1; lk_kind = k; lk_addr = a;
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    m_base[s][ix] = b;
    m_attr[s][ix] = at;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rs_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R8", 64'(rs_valid), 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rs_paddr == e.pa, {e.rq, " R1 paddr"}, 64'(rs_paddr), 64'(e.pa));
        chk(rs_cache == e.cm, {e.rq, " R3 cache"}, 64'(rs_cache), 64'(e.cm));
        chk(rs_cause == e.cz, {e.rq, " R4 cause"}, 64'(rs_cause), 64'(e.cz));
      end
    end
  end

  initial begin
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++) begin
        m_base[s][i] = 3'(i);
        m_attr[s][i] = 4'd2;
      end
    repeat (3) @(negedge clk);
    chk(rs_valid == 1'b0, "R6 reset valid", 64'(rs_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rs_valid == 1'b0, "R6 post-reset idle", 64'(rs_valid), 64'd0);

    // R6: identity map, full rights after reset
    for (int i = 0; i < 8; i++) begin
      look(2'd0, {3'(i), 29'h0ABCDE1 + 29'(i)}, "R6");
      look(2'd1, {3'(i), 29'h1555AAA}, "R6");
      look(2'd2, {3'(i), 29'h0000040}, "R6");
    end

    // R2 R3 R4: sweep of all attribute codes on both banks
    for (int at = 0; at < 16; at++) begin
      wr(1'b1, 3'(at % 8), 3'(7 - (at % 8)), 4'(at));
      wr(1'b0, 3'(at % 8), 3'((at + 3) % 8), 4'(at));
      look(2'd0, {3'(at % 8), 29'h1234567}, "R2");
      look(2'd1, {3'(at % 8), 29'h0FEDCBA}, "R2");
      look(2'd2, {3'(at % 8), 29'h0000104}, "R2");
      look(2'd3, {3'(at % 8), 29'h1FFFFFF}, "R4");
    end

    // R5: banks stay separate
    wr(1'b0, 3'd3, 3'd6, 4'd3);
    wr(1'b1, 3'd3, 3'd1, 4'd15);
    look(2'd2, 32'h6000_0010, "R5");
    look(2'd0, 32'h6000_0010, "R5");
    wr(1'b1, 3'd4, 3'd2, 4'd3);
    look(2'd2, 32'h8000_0020, "R5");
    look(2'd1, 32'h8000_0020, "R5");

    // R7: write and lookup on the same edge, then the next lookup
    wr(1'b1, 3'd5, 3'd5, 4'd4);
    both(1'b1, 3'd5, 3'd0, 4'd15, 2'd0, 32'hA000_0100);
    look(2'd0, 32'hA000_0100, "R7");
    look(2'd1, 32'hBFFF_FFFC, "R7");

    // R8: idle outputs cleared after the last result
    @(negedge clk);
    @(negedge clk);
    chk((rs_valid == 1'b0) && (rs_paddr == 32'd0) && (rs_cause == 2'd0),
        "R8 idle", {31'd0, rs_valid, rs_paddr}, 64'd0);
    chk(sb.size() == 0, "R8 all results seen", 64'(sb.size()), 64'd0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule